// File: doc/BRIEF.md
# Self-Recovering Modulo Up Counter

This block is a binary up counter that steps from zero to a terminal value set by a parameter, then returns to zero. A state machine can use it to time how long it stays in a state. It also serves as a short-period sequence counter, such as one that tracks lines or pixels in a video frame. The period is the terminal value plus one. In most uses that period is not a power of two, so the register can hold codes that normal counting never reaches.

The wrap decision compares for greater-than-or-equal against the terminal value rather than for equality. A flop upset or a control fault can leave a code above the terminal value in the register. On the next enabled clock that code goes back to zero, instead of counting up through the rest of the binary range. The count enable gates every change. A terminal-count pulse marks each enabled cycle that will wrap.

Top module: `recov_mod_counter`

## Requirements
- R1: While the active-low asynchronous reset is low, the count output reads zero.
- R2: On an enabled clock edge with the count below the terminal value, the count rises by exactly one.
- R3: On an enabled clock edge with the count equal to the terminal value, the count returns to zero. After reset the sequence therefore starts at 0 and runs 0, 1, …, terminal, 0, with period terminal+1.
- R4: Any count above the terminal value, up to the all-ones code of the register, becomes zero on the next enabled clock edge.
- R5: With the enable low, the count holds its value on every clock edge. This includes values above the terminal value, which are then cleared on the first enabled edge.
- R6: The terminal pulse is high exactly when the enable is high and the count is at or above the terminal value. It responds combinationally, in the same cycle.
- R7: Under continuous enable the terminal pulse is high for exactly one cycle in each lap of terminal+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| countEn | input | 1 | Count enable; the count advances or wraps only when high |
| countOut | output | WIDTH | Current count value |
| termPulse | output | 1 | High while enabled at or above the terminal value |

## Verification
No port stimulus can drive the counter into a code above its terminal value, so the recovery path is the hardest situation to reach. The bench holds reset low, forces each unreachable code into the count register, and then releases both the force and the reset with the enable low. It checks that the stray value holds while disabled, and that the terminal pulse rises and the count clears on the first enabled edge. A long sweep with an irregular enable pattern covers increment, hold and the ordinary wrap against an arithmetic model.

// File: rtl/recov_mod_counter_pkg.sv
package recov_mod_counter_pkg;

  // Strobes that the control half sends to the datapath each cycle
  typedef struct packed {
    logic advance;  // add one to the count
    logic clear;    // return the count to zero
  } cntStrobes_t;

endpackage

// File: rtl/recov_mod_counter_ctrl.sv
module recov_mod_counter_ctrl
  import recov_mod_counter_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int TERMINAL = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic [WIDTH-1:0] countVal,
  output cntStrobes_t      strobes
);

  localparam logic [WIDTH-1:0] TermVal = WIDTH'(TERMINAL);

  logic atOrAbove;

  // Inclusive compare: every code past the terminal counts as a wrap state
  assign atOrAbove       = (countVal >= TermVal);
  assign strobes.clear   = countEn & atOrAbove;
  assign strobes.advance = countEn & ~atOrAbove;

  // R7
  generate
    if (TERMINAL > 0) begin : g_pulseChk
      tc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.clear |=> !strobes.clear);
    end
  endgenerate

endmodule

// File: rtl/recov_mod_counter_dp.sv
module recov_mod_counter_dp
  import recov_mod_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      strobes,
  output logic [WIDTH-1:0] countVal
);

  logic [WIDTH-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.clear) begin
      countQ <= '0;
    end else if (strobes.advance) begin
      countQ <= countQ + 1'b1;
    end
  end

  assign countVal = countQ;

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> countQ == WIDTH'($past(countQ) + 1'b1));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> countQ == '0);

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.clear) |=> $stable(countQ));

endmodule

// File: rtl/recov_mod_counter.sv
module recov_mod_counter
  import recov_mod_counter_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int TERMINAL = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  output logic [WIDTH-1:0] countOut,
  output logic             termPulse
);

  cntStrobes_t      strobes;
  logic [WIDTH-1:0] countVal;

  recov_mod_counter_ctrl #(
    .WIDTH   (WIDTH),
    .TERMINAL(TERMINAL)
  ) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .countEn (countEn),
    .countVal(countVal),
    .strobes (strobes)
  );

  recov_mod_counter_dp #(
    .WIDTH(WIDTH)
  ) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .countVal(countVal)
  );

  assign countOut  = countVal;
  assign termPulse = strobes.clear;

  // R4
  recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    termPulse |=> countOut == '0);

endmodule

// File: tb/recov_mod_counter_tb_top.sv
module recov_mod_counter_tb_top;

  localparam int W    = 4;
  localparam int TERM = 9;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         countEn = 1'b0;
  logic [W-1:0] countOut;
  logic         termPulse;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  recov_mod_counter #(.WIDTH(W), .TERMINAL(TERM)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .countEn  (countEn),
    .countOut (countOut),
    .termPulse(termPulse)
  );

  task automatic chkCount(input string req, input int exp);
    vectors++;
    if (int'(countOut) != exp) begin
      errors++;
      $display("FAIL %s count actual=%0d expected=%0d", req, countOut, exp);
    end
  endtask

  task automatic chkPulse(input string req, input bit exp);
    vectors++;
    if (termPulse !== exp) begin
      errors++;
      $display("FAIL %s pulse actual=%0b expected=%0b", req, termPulse, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    int expCount;
    int pulses;
    // R1: count is zero while reset is held
    repeat (3) @(negedge clk);
    chkCount("R1", 0);
    countEn = 1'b1;
    #1 chkCount("R1", 0);
    @(negedge clk);
    chkCount("R1", 0);
    rstN = 1'b1;
    countEn = 1'b0;

    // R2 R3 R5 R6: sweep with an irregular enable pattern
    expCount = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      chkCount((countEn ? "R2/R3" : "R5"), expCount);
      countEn = ((i % 7) != 3) && ((i % 11) != 5);
      #1;
      chkPulse("R6", countEn && (expCount >= TERM));
      if (countEn) expCount = (expCount >= TERM) ? 0 : expCount + 1;
    end

    // R3 R7: continuous enable from zero, one pulse per lap
    @(negedge clk);
    countEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    countEn = 1'b1;
    pulses = 0;
    for (int lap = 0; lap < 3; lap++) begin
      for (int k = 0; k <= TERM; k++) begin
        #1;
        chkCount("R3", k);
        if (termPulse) pulses++;
        @(negedge clk);
      end
      vectors++;
      if (pulses != lap + 1) begin
        errors++;
        $display("FAIL R7 pulses actual=%0d expected=%0d", pulses, lap + 1);
      end
    end

    // R4 R5: plant every unreachable code and check the recovery
    for (int v = TERM + 1; v <= MAXV; v++) begin
      @(negedge clk);
      countEn = 1'b0;
      rstN = 1'b0;
      force dut_i.dpI.countQ = W'(v);
      @(negedge clk);
      rstN = 1'b1;
      release dut_i.dpI.countQ;
      #1 chkCount("R5", v);
      chkPulse("R6", 1'b0);
      @(negedge clk);
      chkCount("R5", v);
      countEn = 1'b1;
      #1 chkPulse("R4", 1'b1);
      @(negedge clk);
      chkCount("R4", 0);
      chkPulse("R6", 1'b0);
      @(negedge clk);
      chkCount("R2", 1);
    end

    countEn = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule